// File: doc/BRIEF.md
# Debug Trigger Register Bank with Control Legalization

This block holds the machine-mode registers of a small hardware debug trigger unit. It carries a trigger select register and, for each of two address-match triggers, a control word and a compare-address word. Software reaches all of them through one CSR port made of a 2-bit register address, a write enable, write data and combinational read data. The control word and the compare address of the trigger picked by the select register are the only ones visible at any time.

Every write to a control word is turned into a legal value before it is stored. The trigger type is fixed, fields the design does not implement read as zero, and a size code the design cannot honour collapses to "any size". The stored control and address words of every trigger leave the block on flat buses for a separate match unit. A side query input reports whether a given data register exists for the trigger that is currently selected.

Top module: `trig_csr_bank`

## Requirements
- R1: After reset the select register reads 0, each control word holds only the type value 2 in its top four bits with every other bit zero, and each compare address is zero.
- R2: CSR address 0 is the select register; a write stores every bit of the write data and a read returns it unchanged, including values of 2 or more.
- R3: The top four bits of each control word (bits 63:60 at the default 64-bit width) always read 2, whatever is written there.
- R4: The debug-mode bit (width minus 5), bit 5 and every bit from 7 to width minus 6 that is not a size bit always read zero.
- R5: The size code is bits 22:21 (upper half, 64-bit width only) above bits 17:16. Codes 0, 1, 2, 3 and 5 are stored as written; codes 4 and 6 to 15 store all four size bits as zero.
- R6: Control bits 6 (machine), 4 (supervisor), 3 (user), 2 (execute), 1 (store) and 0 (load) are stored exactly as written.
- R7: CSR address 1 is the control word and address 2 the compare address of the trigger whose index equals the select value; a write there changes that trigger only.
- R8: When the select value is 2 or more, reads of addresses 1 and 2 return zero and writes to them change no trigger.
- R9: The availability output is 1 only when the query index is 1 or 2 (data registers 1 and 2) and the select value is 0 or 1; index 0, index 3 or any select of 2 or more gives 0.
- R10: A compare-address write stores all bits unchanged.
- R11: CSR address 3 (the third data register) always reads zero and writes to it change nothing.
- R12: The per-trigger output buses always carry the stored control and address words, trigger i at bits i*64 upward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrAddr | input | 2 | 0 select, 1 control, 2 compare address, 3 third data register |
| csrWe | input | 1 | Write enable for the addressed register |
| csrWdata | input | XLEN | Write data |
| csrRdata | output | XLEN | Combinational read data of the addressed register |
| availIdx | input | 2 | Data register index for the availability query |
| availOk | output | 1 | Addressed data register exists for the selected trigger |
| trigCtrl | output | NUM_TRIG*XLEN | Stored control words, trigger i at slice i |
| trigAddr | output | NUM_TRIG*XLEN | Stored compare addresses, trigger i at slice i |

## Verification
Control writes carry fully random 64-bit data, so every unimplemented field, the debug-mode bit and the type field receive both ones and zeros, which separates correct masking from a stuck or copied bit. A directed sweep writes all sixteen size codes to tell the supported set from the dropped set, including the code 5 and code 4 neighbours. Select writes mix the two valid indices with 2, 3 and large random values, so routing, out-of-range read-as-zero and ignored writes are told apart by reading back both triggers after each access. The availability query is tried for all four indices under valid and invalid selections.

// File: rtl/trig_csr_pkg.sv
package trig_csr_pkg;

  typedef enum logic [1:0] {
    ADDR_SEL   = 2'd0,
    ADDR_CTRL  = 2'd1,
    ADDR_MATCH = 2'd2,
    ADDR_RSVD  = 2'd3
  } csr_addr_e;

  typedef enum logic [1:0] {
    RD_SEL   = 2'd0,
    RD_CTRL  = 2'd1,
    RD_MATCH = 2'd2,
    RD_ZERO  = 2'd3
  } rd_src_e;

  typedef struct packed {
    logic    wrSel;
    logic    wrCtrl;
    logic    wrMatch;
    rd_src_e rdSrc;
  } csr_strobe_t;

  localparam logic [3:0] TRIG_TYPE_MATCH = 4'd2;

endpackage

// File: rtl/trig_legalize.sv
module trig_legalize
  import trig_csr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] rawVal,
  output logic [XLEN-1:0] legalVal
);
  localparam bit  IS64     = (XLEN == 64);
  localparam int  TYPE_LSB = XLEN - 4;
  localparam logic [XLEN-1:0] KEEP_MASK = XLEN'(64'h5F);
  localparam logic [XLEN-1:0] SIZE_MASK = IS64 ? XLEN'(64'h0063_0000) : XLEN'(64'h0003_0000);
  localparam logic [XLEN-1:0] TYPE_BITS = XLEN'(TRIG_TYPE_MATCH) << TYPE_LSB;

  logic [3:0] sizeCode;
  logic       sizeOk;

  always_comb begin
    if (IS64) sizeCode = {rawVal[22:21], rawVal[17:16]};
    else      sizeCode = {2'b00, rawVal[17:16]};
  end

  always_comb begin
    unique case (sizeCode)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd5: sizeOk = 1'b1;
      default:                      sizeOk = 1'b0;
    endcase
  end

  assign legalVal = TYPE_BITS | (rawVal & KEEP_MASK) | (sizeOk ? (rawVal & SIZE_MASK) : '0);
endmodule

// File: rtl/trig_csr_ctrl.sv
module trig_csr_ctrl
  import trig_csr_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int NUM_TRIG = 2
) (
  input  logic [1:0]      csrAddr,
  input  logic            csrWe,
  input  logic [XLEN-1:0] selQ,
  input  logic [1:0]      availIdx,
  output csr_strobe_t     strobe,
  output logic            availOk
);
  logic selOk;
  assign selOk = (selQ < XLEN'(NUM_TRIG));

  always_comb begin
    strobe = '{wrSel: 1'b0, wrCtrl: 1'b0, wrMatch: 1'b0, rdSrc: RD_ZERO};
    unique case (csr_addr_e'(csrAddr))
      ADDR_SEL: begin
        strobe.wrSel = csrWe;
        strobe.rdSrc = RD_SEL;
      end
      ADDR_CTRL: begin
        strobe.wrCtrl = csrWe && selOk;
        strobe.rdSrc  = selOk ? RD_CTRL : RD_ZERO;
      end
      ADDR_MATCH: begin
        strobe.wrMatch = csrWe && selOk;
        strobe.rdSrc   = selOk ? RD_MATCH : RD_ZERO;
      end
      default: strobe.rdSrc = RD_ZERO;
    endcase
  end

  assign availOk = selOk && ((availIdx == 2'd1) || (availIdx == 2'd2));
endmodule

// File: rtl/trig_csr_dp.sv
module trig_csr_dp
  import trig_csr_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int NUM_TRIG = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  csr_strobe_t              strobe,
  input  logic [XLEN-1:0]          csrWdata,
  output logic [XLEN-1:0]          csrRdata,
  output logic [XLEN-1:0]          selQ,
  output logic [NUM_TRIG*XLEN-1:0] trigCtrl,
  output logic [NUM_TRIG*XLEN-1:0] trigAddr
);
  localparam int IDXW = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;
  localparam logic [XLEN-1:0] CTRL_RESET = XLEN'(TRIG_TYPE_MATCH) << (XLEN - 4);

  logic [XLEN-1:0] legalCtrl;
  logic [XLEN-1:0] ctrlQ [NUM_TRIG];
  logic [XLEN-1:0] addrQ [NUM_TRIG];
  logic [IDXW-1:0] curIdx;
  logic [XLEN-1:0] ctrlSel;
  logic [XLEN-1:0] addrSel;

  trig_legalize #(.XLEN(XLEN)) legal_i (
    .rawVal  (csrWdata),
    .legalVal(legalCtrl)
  );

  always_ff @(posedge clk) begin
    if (!rstN)              selQ <= '0;
    else if (strobe.wrSel)  selQ <= csrWdata;
  end

  assign curIdx = selQ[IDXW-1:0];

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
    logic hitIdx;
    assign hitIdx = (curIdx == IDXW'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrlQ[i] <= CTRL_RESET;
        addrQ[i] <= '0;
      end else begin
        if (strobe.wrCtrl && hitIdx)  ctrlQ[i] <= legalCtrl;
        if (strobe.wrMatch && hitIdx) addrQ[i] <= csrWdata;
      end
    end

    assign trigCtrl[i*XLEN +: XLEN] = ctrlQ[i];
    assign trigAddr[i*XLEN +: XLEN] = addrQ[i];
  end

  always_comb begin
    ctrlSel = '0;
    addrSel = '0;
    for (int k = 0; k < NUM_TRIG; k++) begin
      if (curIdx == IDXW'(k)) begin
        ctrlSel = ctrlQ[k];
        addrSel = addrQ[k];
      end
    end
  end

  always_comb begin
    unique case (strobe.rdSrc)
      RD_SEL:   csrRdata = selQ;
      RD_CTRL:  csrRdata = ctrlSel;
      RD_MATCH: csrRdata = addrSel;
      default:  csrRdata = '0;
    endcase
  end
endmodule

// File: rtl/trig_csr_bank.sv
module trig_csr_bank
  import trig_csr_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int NUM_TRIG = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               csrAddr,
  input  logic                     csrWe,
  input  logic [XLEN-1:0]          csrWdata,
  output logic [XLEN-1:0]          csrRdata,
  input  logic [1:0]               availIdx,
  output logic                     availOk,
  output logic [NUM_TRIG*XLEN-1:0] trigCtrl,
  output logic [NUM_TRIG*XLEN-1:0] trigAddr
);
  csr_strobe_t     strobe;
  logic [XLEN-1:0] selVal;

  trig_csr_ctrl #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG)) ctrl_i (
    .csrAddr (csrAddr),
    .csrWe   (csrWe),
    .selQ    (selVal),
    .availIdx(availIdx),
    .strobe  (strobe),
    .availOk (availOk)
  );

  trig_csr_dp #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .csrWdata(csrWdata),
    .csrRdata(csrRdata),
    .selQ    (selVal),
    .trigCtrl(trigCtrl),
    .trigAddr(trigAddr)
  );
endmodule

// File: rtl/trig_csr_bank_chk.sv
module trig_csr_bank_chk #(
  parameter int XLEN     = 64,
  parameter int NUM_TRIG = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [1:0]               csrAddr,
  input logic                     csrWe,
  input logic [XLEN-1:0]          csrRdata,
  input logic [1:0]               availIdx,
  input logic                     availOk,
  input logic [XLEN-1:0]          selQ,
  input logic [NUM_TRIG*XLEN-1:0] trigCtrl,
  input logic [NUM_TRIG*XLEN-1:0] trigAddr
);
  localparam bit IS64 = (XLEN == 64);
  localparam logic [XLEN-1:0] OK_MASK =
    (XLEN'(64'hF) << (XLEN - 4)) | XLEN'(64'h5F) |
    (IS64 ? XLEN'(64'h0063_0000) : XLEN'(64'h0003_0000));

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_chk
    logic [XLEN-1:0] c;
    logic [3:0]      code;
    assign c    = trigCtrl[i*XLEN +: XLEN];
    assign code = IS64 ? {c[22:21], c[17:16]} : {2'b00, c[17:16]};

    a_r3_type_fixed: assert property (@(posedge clk) disable iff (!rstN)
      c[XLEN-1:XLEN-4] == 4'd2);

    a_r4_unimpl_zero: assert property (@(posedge clk) disable iff (!rstN)
      (c & ~OK_MASK) == '0);

    a_r5_size_legal: assert property (@(posedge clk) disable iff (!rstN)
      (code <= 4'd3) || (code == 4'd5));

    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
      !(csrWe && csrAddr == 2'd2 && selQ == XLEN'(i)) |=> $stable(trigAddr[i*XLEN +: XLEN]));
  end

  a_r8_oob_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((csrAddr == 2'd1 || csrAddr == 2'd2) && selQ >= XLEN'(NUM_TRIG)) |-> csrRdata == '0);

  a_r11_rsvd_zero: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr == 2'd3) |-> csrRdata == '0);

  a_r9_avail: assert property (@(posedge clk) disable iff (!rstN)
    availOk |-> (selQ < XLEN'(NUM_TRIG) && (availIdx == 2'd1 || availIdx == 2'd2)));
endmodule

bind trig_csr_bank trig_csr_bank_chk #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .csrAddr (csrAddr),
  .csrWe   (csrWe),
  .csrRdata(csrRdata),
  .availIdx(availIdx),
  .availOk (availOk),
  .selQ    (selVal),
  .trigCtrl(trigCtrl),
  .trigAddr(trigAddr)
);

// File: tb/trig_csr_bank_tb_top.sv
module trig_csr_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;
  localparam int NT   = 2;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [1:0]      csrAddr = 2'd0;
  logic            csrWe = 1'b0;
  logic [XLEN-1:0] csrWdata = '0;
  logic [XLEN-1:0] csrRdata;
  logic [1:0]      availIdx = 2'd0;
  logic            availOk;
  logic [NT*XLEN-1:0] trigCtrl;
  logic [NT*XLEN-1:0] trigAddr;

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  logic [63:0] selM;
  logic [63:0] ctrlM [NT];
  logic [63:0] addrM [NT];

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_csr_bank #(.XLEN(XLEN), .NUM_TRIG(NT)) dut_i (
    .clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrWe(csrWe),
    .csrWdata(csrWdata), .csrRdata(csrRdata), .availIdx(availIdx),
    .availOk(availOk), .trigCtrl(trigCtrl), .trigAddr(trigAddr)
  );

  function automatic logic [63:0] expLegal(input logic [63:0] v);
    logic [63:0] r;
    logic [3:0]  code;
    r = '0;
    r[63:60] = 4'd2;
    r[6]   = v[6];
    r[4:3] = v[4:3];
    r[2:0] = v[2:0];
    code = {v[22:21], v[17:16]};
    if (code == 4'd0 || code == 4'd1 || code == 4'd2 || code == 4'd3 || code == 4'd5) begin
      r[17:16] = v[17:16];
      r[22:21] = v[22:21];
    end
    return r;
  endfunction

  task automatic cmp(input logic [63:0] act, input logic [63:0] exp, input string req);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    csrAddr = a; csrWdata = d; csrWe = 1'b1;
    @(negedge clk);
    csrWe = 1'b0;
    case (a)
      2'd0: selM = d;
      2'd1: if (selM < NT) ctrlM[selM[0]] = expLegal(d);
      2'd2: if (selM < NT) addrM[selM[0]] = d;
      default: ;
    endcase
  endtask

  task automatic readCheck(input logic [1:0] a, input string req);
    logic [63:0] e;
    csrAddr = a;
    #1;
    case (a)
      2'd0: e = selM;
      2'd1: e = (selM < NT) ? ctrlM[selM[0]] : 64'd0;
      2'd2: e = (selM < NT) ? addrM[selM[0]] : 64'd0;
      default: e = 64'd0;
    endcase
    cmp(csrRdata, e, req);
  endtask

  task automatic outCheck();
    for (int i = 0; i < NT; i++) begin
      cmp(trigCtrl[i*XLEN +: XLEN], ctrlM[i], "R12 ctrl out");
      cmp(trigAddr[i*XLEN +: XLEN], addrM[i], "R12 addr out");
    end
  endtask

  task automatic fullCheck();
    string rq;
    rq = (selM < NT) ? "R7 routed" : "R8 out of range";
    readCheck(2'd0, "R2 select");
    readCheck(2'd1, rq);
    readCheck(2'd2, rq);
    readCheck(2'd3, "R11 reserved");
    outCheck();
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    void'($urandom(32'd4242));
    selM = '0;
    for (int i = 0; i < NT; i++) begin
      ctrlM[i] = 64'h2000_0000_0000_0000;
      addrM[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readCheck(2'd0, "R1 reset select");
    for (int i = 0; i < NT; i++) begin
      cmp(trigCtrl[i*XLEN +: XLEN], 64'h2000_0000_0000_0000, "R1 reset ctrl");
      cmp(trigAddr[i*XLEN +: XLEN], 64'd0, "R1 reset addr");
    end

    // R3 R4: all ones and type overwrite attempts
    doWrite(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    readCheck(2'd1, "R3 R4 all ones");
    doWrite(2'd1, 64'h7800_0000_0000_0000);
    readCheck(2'd1, "R3 type write ignored");

    // R6 mode and access bits
    doWrite(2'd1, 64'h0000_0000_0000_005F);
    readCheck(2'd1, "R6 keep bits");
    cmp(csrRdata[6:0], 7'h5F, "R6 keep bits low");

    // R5 size sweep on trigger 1
    doWrite(2'd0, 64'd1);
    for (int c = 0; c < 16; c++) begin
      logic [63:0] v;
      v = 64'h0000_0000_0000_0041;
      v[17:16] = c[1:0];
      v[22:21] = c[3:2];
      doWrite(2'd1, v);
      readCheck(2'd1, "R5 size code");
    end

    // R10 address full width
    doWrite(2'd2, 64'hDEAD_BEEF_0123_4567);
    readCheck(2'd2, "R10 addr");
    fullCheck();

    // R2 R8 large select, writes ignored
    doWrite(2'd0, 64'h8000_0000_0000_0002);
    doWrite(2'd1, 64'h0000_0000_0000_0007);
    doWrite(2'd2, 64'h1111_2222_3333_4444);
    fullCheck();
    doWrite(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    fullCheck();

    // R9 availability sweep
    for (int s = 0; s < 4; s++) begin
      doWrite(2'd0, 64'(s));
      for (int q = 0; q < 4; q++) begin
        availIdx = q[1:0];
        #1;
        cmp({63'd0, availOk}, {63'd0, (s < NT) && (q == 1 || q == 2)}, "R9 avail");
      end
    end

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [1:0]  a;
      logic [63:0] d;
      a = 2'($urandom % 4);
      d = rnd64();
      if (a == 2'd0) begin
        case ($urandom % 5)
          0, 1:    d = 64'(d[0]);
          2:       d = 64'd2;
          3:       d = 64'd3;
          default: ;
        endcase
      end
      doWrite(a, d);
      fullCheck();
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nCmp++;
        nBad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule